// File: doc/BRIEF.md
# Dirty Region Write-Policy Tracker

This block chooses the write policy of a large memory-side cache one 4KB page at a time, so that most of the cache holds only clean lines. Each write's page number is hashed three different ways into three banks of small saturating counters; the smallest of the three indexed counters is the page's estimated write count. Once that estimate rises above a threshold, the page is promoted into a short, fully associative list of page tags. Pages on that list are operated write-back. Every other page is operated write-through, so it can never hold dirty data.

A lookup port reports, within the same cycle, whether the page of an address may hold dirty lines. When a promotion needs a slot and the list is full, a victim is chosen by a not-recently-used scheme. The victim's page tag is reported with a one-cycle pulse so that the surrounding cache can flush its dirty lines. The flush and the cache data path are outside this block.

Top module: `dirty_region_tracker`

## Requirements
- R1: The page number is the address shifted right by PAGE_SHIFT (12, so 4KB pages). Two addresses in the same page always get the same answer on every port.
- R2: Hash k (k = 0, 1, 2) rotates the PAGE_W-bit page number left by (7·k mod PAGE_W) bits. It then XORs together the IDX_W-bit chunks of the result, starting at bit 0 and padding the top chunk with zeros, to give the counter index in bank k.
- R3: Each accepted write adds one to the indexed counter in each of the three banks. A counter saturates at 2^CNT_W−1 (15). The page estimate is the minimum of the three incremented values.
- R4: A write whose page is not on the list is promoted when its incremented estimate is strictly greater than wr_threshold, which is sampled with the write. A threshold of 15 therefore never promotes.
- R5: On a promotion, each of the three indexed counters is written with its incremented value shifted right by one, instead of with the incremented value.
- R6: lk_dirty is 1 in the same cycle exactly when lk_addr's page is a valid list entry. After reset the list is empty, every counter is zero, lk_dirty is 0 and evict_valid is 0.
- R7: A promotion writes into the lowest-index invalid entry. If every entry is valid, it writes into the lowest-index entry whose NRU bit is clear, and in the next cycle evict_valid is 1 for exactly one cycle while evict_page holds the replaced tag.
- R8: The entries touched in a cycle have their NRU bits set. An entry is touched by a lookup hit with lk_valid, by a write that hits it, or by an insertion. If that would leave all NRU bits set, only the touched entries keep their bits and all others are cleared.
- R9: A write to a page already on the list never promotes it again and never causes an eviction, though its counters still increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A write request is present this cycle |
| wr_addr | input | ADDR_W | Address of the write |
| wr_threshold | input | CNT_W | Estimate must exceed this to promote |
| lk_valid | input | 1 | Lookup counts as a use for NRU |
| lk_addr | input | ADDR_W | Address being looked up |
| lk_dirty | output | 1 | Page of lk_addr may hold dirty lines |
| evict_valid | output | 1 | One-cycle pulse: a list entry was replaced |
| evict_page | output | ADDR_W−PAGE_SHIFT | Page tag that was replaced |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4KB pages, three banks of 64 four-bit counters and a 16-entry list. At this size an arithmetic model in the bench can track every counter and every entry exactly. It sweeps every threshold from 0 to 15 on a fresh page, so promotion is seen to happen on exactly the write after the threshold and never at 15. It overfills the list, which brings the full-list victim order and the NRU clear-out into reach. A long mixed run of writes and lookups over a small pool of pages then forces hash collisions, saturation, halving after promotion, and repeated evictions, all compared cycle by cycle.

// File: rtl/drt_pkg.sv
package drt_pkg;

    localparam int NUM_HASH      = 3;
    localparam int HASH_ROT_STEP = 7;

    typedef enum logic [1:0] {
        WR_IDLE    = 2'd0,
        WR_COUNT   = 2'd1,
        WR_PROMOTE = 2'd2,
        WR_LISTED  = 2'd3
    } wr_action_e;

endpackage

// File: rtl/drt_page_hash.sv
module drt_page_hash #(
    parameter int PAGE_W = 20,
    parameter int IDX_W  = 6,
    parameter int ROT    = 0
) (
    input  logic [PAGE_W-1:0] page,
    output logic [IDX_W-1:0]  idx
);
    localparam int R     = ROT % PAGE_W;
    localparam int NCH   = (PAGE_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W = NCH * IDX_W;

    logic [PAGE_W-1:0] rotated;
    logic [PAD_W-1:0]  padded;

    generate
        if (R == 0) begin : g_norot
            assign rotated = page;
        end else begin : g_rot
            assign rotated = {page[PAGE_W-R-1:0], page[PAGE_W-1:PAGE_W-R]};
        end
    endgenerate

    assign padded = PAD_W'(rotated);

    always_comb begin
        idx = '0;
        for (int c = 0; c < NCH; c++) begin
            idx = idx ^ padded[c*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/drt_count_filter.sv
module drt_count_filter
    import drt_pkg::*;
#(
    parameter int PAGE_W = 20,
    parameter int CNT_W  = 4,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              promote,
    input  logic [PAGE_W-1:0] page,
    output logic [CNT_W-1:0]  est_next
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [IDX_W-1:0] idx [NUM_HASH];
    logic [CNT_W-1:0] cur [NUM_HASH];
    logic [CNT_W-1:0] inc [NUM_HASH];

    generate
        for (genvar k = 0; k < NUM_HASH; k++) begin : g_bank
            logic [CNT_W-1:0] mem [DEPTH];

            drt_page_hash #(
                .PAGE_W(PAGE_W),
                .IDX_W (IDX_W),
                .ROT   (k * HASH_ROT_STEP)
            ) u_hash (
                .page(page),
                .idx (idx[k])
            );

            assign cur[k] = mem[idx[k]];
            assign inc[k] = (cur[k] == CNT_MAX) ? CNT_MAX : cur[k] + 1'b1;

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
                end else if (wr_en) begin
                    mem[idx[k]] <= promote ? (inc[k] >> 1) : inc[k];
                end
            end
        end
    endgenerate

    always_comb begin
        est_next = inc[0];
        for (int k = 1; k < NUM_HASH; k++) begin
            if (inc[k] < est_next) est_next = inc[k];
        end
    end
endmodule

// File: rtl/drt_dirty_list.sv
module drt_dirty_list #(
    parameter int PAGE_W = 20,
    parameter int LIST_N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [PAGE_W-1:0] lk_page,
    input  logic              wr_valid,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic              ins_en,
    output logic              lk_hit,
    output logic              wr_hit,
    output logic              evict_valid,
    output logic [PAGE_W-1:0] evict_page,
    output logic [LIST_N-1:0] valid_vec,
    output logic [LIST_N-1:0] nru_vec,
    output logic [LIST_N-1:0] lk_match
);
    localparam int SLOT_W = (LIST_N > 1) ? $clog2(LIST_N) : 1;

    typedef struct packed {
        logic              valid;
        logic              nru;
        logic [PAGE_W-1:0] tag;
    } entry_t;

    entry_t            ent [LIST_N];
    logic [LIST_N-1:0] wr_match;
    logic [LIST_N-1:0] touch;
    logic [LIST_N-1:0] nru_next;
    logic [LIST_N-1:0] slot_oh;
    logic              have_free;
    logic              have_old;
    logic [SLOT_W-1:0] free_idx;
    logic [SLOT_W-1:0] old_idx;
    logic [SLOT_W-1:0] slot;

    generate
        for (genvar i = 0; i < LIST_N; i++) begin : g_ent
            assign lk_match[i]  = ent[i].valid && (ent[i].tag == lk_page);
            assign wr_match[i]  = ent[i].valid && (ent[i].tag == wr_page);
            assign valid_vec[i] = ent[i].valid;
            assign nru_vec[i]   = ent[i].nru;
            assign slot_oh[i]   = (slot == SLOT_W'(i));
        end
    endgenerate

    assign lk_hit = |lk_match;
    assign wr_hit = |wr_match;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        have_old  = 1'b0;
        old_idx   = '0;
        for (int i = 0; i < LIST_N; i++) begin
            if (!have_free && !ent[i].valid) begin
                have_free = 1'b1;
                free_idx  = SLOT_W'(i);
            end
            if (!have_old && ent[i].valid && !ent[i].nru) begin
                have_old = 1'b1;
                old_idx  = SLOT_W'(i);
            end
        end
        slot = have_free ? free_idx : old_idx;
    end

    always_comb begin
        touch = '0;
        if (lk_valid) touch = touch | lk_match;
        if (wr_valid) touch = touch | wr_match;
        if (ins_en)   touch = touch | slot_oh;
        nru_next = nru_vec | touch;
        if (&nru_next) nru_next = touch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LIST_N; i++) ent[i] <= '0;
            evict_valid <= 1'b0;
            evict_page  <= '0;
        end else begin
            for (int i = 0; i < LIST_N; i++) ent[i].nru <= nru_next[i];
            evict_valid <= ins_en && !have_free;
            if (ins_en) begin
                ent[slot].valid <= 1'b1;
                ent[slot].tag   <= wr_page;
                if (!have_free) evict_page <= ent[slot].tag;
            end
        end
    end
endmodule

// File: rtl/dirty_region_tracker.sv
module dirty_region_tracker
    import drt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int CNT_W      = 4,
    parameter int IDX_W      = 6,
    parameter int LIST_N     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_valid,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CNT_W-1:0]             wr_threshold,
    input  logic                         lk_valid,
    input  logic [ADDR_W-1:0]            lk_addr,
    output logic                         lk_dirty,
    output logic                         evict_valid,
    output logic [ADDR_W-PAGE_SHIFT-1:0] evict_page
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

    logic [PAGE_W-1:0] wr_page;
    logic [PAGE_W-1:0] lk_page;
    logic [CNT_W-1:0]  est_next;
    logic              wr_hit;
    logic              lk_hit;
    logic              promote;
    wr_action_e        action;
    logic [LIST_N-1:0] valid_vec;
    logic [LIST_N-1:0] nru_vec;
    logic [LIST_N-1:0] lk_match_vec;
    logic              unused_offset_bits;

    assign wr_page = wr_addr[ADDR_W-1:PAGE_SHIFT];
    assign lk_page = lk_addr[ADDR_W-1:PAGE_SHIFT];
    assign unused_offset_bits = ^{wr_addr[PAGE_SHIFT-1:0], lk_addr[PAGE_SHIFT-1:0]};

    always_comb begin
        if (!wr_valid)                 action = WR_IDLE;
        else if (wr_hit)               action = WR_LISTED;
        else if (est_next > wr_threshold) action = WR_PROMOTE;
        else                           action = WR_COUNT;
    end

    assign promote = (action == WR_PROMOTE);

    drt_count_filter #(
        .PAGE_W(PAGE_W),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_filter (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_valid),
        .promote (promote),
        .page    (wr_page),
        .est_next(est_next)
    );

    drt_dirty_list #(
        .PAGE_W(PAGE_W),
        .LIST_N(LIST_N)
    ) u_list (
        .clk        (clk),
        .rst        (rst),
        .lk_valid   (lk_valid),
        .lk_page    (lk_page),
        .wr_valid   (wr_valid),
        .wr_page    (wr_page),
        .ins_en     (promote),
        .lk_hit     (lk_hit),
        .wr_hit     (wr_hit),
        .evict_valid(evict_valid),
        .evict_page (evict_page),
        .valid_vec  (valid_vec),
        .nru_vec    (nru_vec),
        .lk_match   (lk_match_vec)
    );

    assign lk_dirty = lk_hit;
endmodule

// File: rtl/drt_checks.sv
module drt_checks #(
    parameter int LIST_N = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              promote,
    input logic              evict_valid,
    input logic [LIST_N-1:0] valid_vec,
    input logic [LIST_N-1:0] nru_vec,
    input logic [LIST_N-1:0] lk_match_vec
);
    a_r7_evict_follows_promote: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> $past(promote));

    a_r7_evict_only_when_full: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> $past(&valid_vec));

    a_r8_nru_never_all_set: assert property (@(posedge clk) disable iff (rst)
        !(&nru_vec));

    a_r6_single_tag_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match_vec));

    a_r4_entries_never_dropped: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_vec) >= $past($countones(valid_vec)));
endmodule

bind dirty_region_tracker drt_checks #(.LIST_N(LIST_N)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .promote     (promote),
    .evict_valid (evict_valid),
    .valid_vec   (valid_vec),
    .nru_vec     (nru_vec),
    .lk_match_vec(lk_match_vec)
);

// File: tb/dirty_region_tracker_tb.sv
`timescale 1ns/1ps
module dirty_region_tracker_tb;
    localparam int NB = 3;
    localparam int DEPTH = 64;
    localparam int LN = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [3:0]  wr_threshold = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_dirty;
    logic        evict_valid;
    logic [19:0] evict_page;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int seed = 12345;

    int m_cnt [NB][DEPTH];
    bit m_val [LN];
    int m_tag [LN];
    bit m_nru [LN];

    always #2.5 clk = ~clk;

    dirty_region_tracker u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_threshold(wr_threshold), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_dirty(lk_dirty), .evict_valid(evict_valid), .evict_page(evict_page)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int hsh(int page, int k);
        int r = (k * 7) % 20;
        logic [19:0] p = 20'(page);
        logic [19:0] rt = (r == 0) ? p : ((p << r) | (p >> (20 - r)));
        int h = 0;
        for (int c = 0; c < 4; c++) h = h ^ ((int'(rt) >> (6 * c)) & 63);
        return h;
    endfunction

    function automatic int find(int page);
        for (int i = 0; i < LN; i++) if (m_val[i] && m_tag[i] == page) return i;
        return -1;
    endfunction

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fffff;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NB; k++) for (int i = 0; i < DEPTH; i++) m_cnt[k][i] = 0;
        for (int i = 0; i < LN; i++) begin m_val[i] = 0; m_tag[i] = 0; m_nru[i] = 0; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_valid = 1'b0; lk_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // One cycle: drive at negedge, check lookup before the edge, update model,
    // check eviction pulse after the edge. Returns model dirty flag for lk.
    task automatic cyc(bit wv, int wpage, int thr, bit lv, int lpage, int off, string tag);
        int widx [NB];
        int inc [NB];
        int est, wh, lh, slot, ev, evp;
        bit prom;
        bit touch [LN];
        bit allset;
        wr_valid = wv; wr_addr = {20'(wpage), 12'(off)};
        wr_threshold = 4'(thr);
        lk_valid = lv; lk_addr = {20'(lpage), 12'(off * 3)};
        #1;
        lh = find(lpage);
        chk({tag, " R6 lookup"}, int'(lk_dirty), (lh >= 0) ? 1 : 0);
        for (int i = 0; i < LN; i++) touch[i] = 0;
        ev = 0; evp = 0; prom = 0;
        if (lv && lh >= 0) touch[lh] = 1;
        if (wv) begin
            wh = find(wpage);
            est = 99;
            for (int k = 0; k < NB; k++) begin
                widx[k] = hsh(wpage, k);
                inc[k] = (m_cnt[k][widx[k]] == 15) ? 15 : m_cnt[k][widx[k]] + 1;
                if (inc[k] < est) est = inc[k];
            end
            prom = (wh < 0) && (est > thr);
            for (int k = 0; k < NB; k++) m_cnt[k][widx[k]] = prom ? (inc[k] >> 1) : inc[k];
            if (wh >= 0) touch[wh] = 1;
            if (prom) begin
                slot = -1;
                for (int i = 0; i < LN; i++) if (slot < 0 && !m_val[i]) slot = i;
                if (slot < 0) begin
                    for (int i = 0; i < LN; i++) if (slot < 0 && !m_nru[i]) slot = i;
                    ev = 1; evp = m_tag[slot];
                end
                m_val[slot] = 1; m_tag[slot] = wpage; touch[slot] = 1;
            end
        end
        allset = 1;
        for (int i = 0; i < LN; i++) if (!(m_nru[i] | touch[i])) allset = 0;
        for (int i = 0; i < LN; i++) m_nru[i] = allset ? touch[i] : (m_nru[i] | touch[i]);
        @(negedge clk);
        chk({tag, " R7 evict_valid"}, int'(evict_valid), ev);
        if (ev) chk({tag, " R7 evict_page"}, int'(evict_page), evp);
    endtask

    initial begin
        int pool [40];
        do_reset();
        // R6: reset state
        #1;
        chk("R6 reset lk_dirty", int'(lk_dirty), 0);
        chk("R6 reset evict_valid", int'(evict_valid), 0);

        // R4/R3: threshold sweep, promotion exactly on write thr+1
        for (int t = 0; t < 16; t++) begin
            int pg = 'h1234 + t * 97;
            do_reset();
            for (int n = 1; n <= 17; n++) begin
                cyc(1, pg, t, 1, pg, n, "R4 sweep");
                #1;
                chk("R4 promoted after write", int'(lk_dirty), (t < 15 && n > t) ? 1 : 0);
            end
        end

        // R1: offsets within a page give the same answer
        cyc(0, 0, 0, 0, 'h1234 + 15 * 97, 0, "R1 offset");
        cyc(0, 0, 0, 0, 'h1234 + 15 * 97, 4095, "R1 offset");

        // R7/R8: overfill the list
        do_reset();
        for (int i = 0; i < 20; i++) cyc(1, 'h400 + i * 13, 0, 0, 0, i, "R7 fill");
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, 'h400 + i * 13, 0, "R8 probe");

        // R9: repeated writes to a listed page
        for (int i = 0; i < 20; i++) cyc(1, 'h400 + 19 * 13, 0, 1, 'h400 + 19 * 13, i, "R9 listed");

        // R5/R3/R2/R8: mixed traffic over a small pool, model-compared
        do_reset();
        for (int i = 0; i < 40; i++) pool[i] = rnd() & 20'hfffff;
        for (int n = 0; n < 4000; n++) begin
            int r = rnd();
            cyc((r & 3) != 0, pool[(r >> 2) % 40], (r >> 9) % 8,
                ((r >> 12) & 1) == 1, pool[(r >> 13) % 40], r & 4095, "R5 mixed");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule